// File: doc/BRIEF.md
# Linked Descriptor Chain Transfer Sequencer

This block runs one DMA channel from a chain of 32-byte transfer descriptors kept in memory. A start strobe hands it the address of the first descriptor. The sequencer fetches that descriptor's eight words and loads the working copy. It then moves data: every beat reads one element from the source address and writes the same element to the destination address. Both addresses advance by their own signed offsets. One pass over the minor byte count makes one major iteration, and the major count sets how many passes run.

When the last major iteration ends, the descriptor's scatter-gather bit decides what comes next. If the bit is set, the last-destination word is taken as the address of the next descriptor, and that descriptor is fetched and started without outside help. If the bit is clear, the chain ends and the channel reports done. A one-cycle interrupt pulse can be raised at the half-way point of the major loop and at its end, for each descriptor that asks for it. A failed memory access stops the channel and raises an error flag. So does a descriptor whose configuration cannot be run.

Every memory access goes through a single request channel that uses a valid/ready handshake. After the master raises `req_valid`, it holds address, direction, size and write data unchanged until `req_ready` is sampled high. The slave may hold `req_ready` low for any number of cycles. Exactly one request is outstanding at a time. The slave returns exactly one `rsp_valid` pulse for each accepted request, at least one cycle later. The sequencer is always able to take that response, so the response channel has no ready.

Top module: `sgchain_seq`

## Requirements
- R1: Starting from idle, a `start` pulse clears done and error, raises active on the next cycle, and issues eight 4-byte reads (size code 2) at the descriptor address plus 0, 4, ..., 28, in that order.
- R2: Descriptor layout, word offsets in bytes: +0 source address; +4 holds source size in bits 26:24, destination size in bits 18:16 and signed source offset in bits 15:0; +8 minor byte count; +16 destination address; +20 holds the starting major count in bits 24:16 and signed destination offset in bits 15:0; +24 next-descriptor address; +28 holds the beginning count in bits 24:16, scatter-gather enable in bit 4, half interrupt enable in bit 2, end interrupt enable in bit 1 and start in bit 0. The word at +12 and all other bits are read and have no effect.
- R3: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. A beat is a read of the source size at the source address, followed by a write of the returned data (bits above the element zeroed) to the destination address. After each beat, source and destination advance by their sign-extended offsets. A major iteration is byte count divided by beat size beats, and the starting major count gives the number of iterations.
- R4: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged.
- R5: When a descriptor with scatter-gather enabled finishes its last iteration, the sequencer fetches the descriptor at its next-descriptor address. That descriptor runs only if its start bit is set. Otherwise the channel goes inactive with neither done nor error.
- R6: When a descriptor with scatter-gather clear finishes, done rises and active falls on the same edge. Done stays high until the next accepted start.
- R7: When end interrupt enable is set, `irq` pulses for one cycle after the last beat of the final iteration, before any further request.
- R8: When half interrupt enable is set, `irq` pulses after an iteration that leaves the remaining count equal to half the beginning count (rounded down), provided that value is non-zero.
- R9: A response with `rsp_err` set stops the chain. Error goes high, active falls, done stays low, and no further request is issued.
- R10: A loaded descriptor with a size code above 2, unequal source and destination sizes, a zero byte count, a byte count that is not a multiple of the beat size, or a zero starting count sets error with no data access.
- R11: A `start` pulse while the channel is active has no effect on the running chain.
- R12: After reset, active, done, error, `irq` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain (honoured only when idle) |
| chain_base | input | ADDR_W | Address of the first descriptor |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Byte address of the access |
| req_size | output | 2 | Element size code (0:1, 1:2, 2:4 bytes) |
| req_wdata | output | 32 | Write data, right-aligned |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_rdata | input | 32 | Read data, right-aligned |
| rsp_err | input | 1 | The access failed |
| done | output | 1 | Chain finished normally |
| active | output | 1 | Channel is running |
| irq | output | 1 | One-cycle interrupt pulse |
| err | output | 1 | Chain stopped on an error |

## Verification
The assertions take for granted that the memory slave answers each accepted request with exactly one response, never answers while nothing is outstanding, and never answers in the cycle of the handshake itself. The bench responder keeps to this. It records each handshake, answers after a latency of zero to two extra cycles, and drops `req_ready` at pseudo-random times to exercise back-pressure. Descriptors in the stimulus give equal beginning and starting counts, and source regions never overlap destination regions. The behavioural model can therefore read source data at build time.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int CNT_W      = 9;
  localparam int OFF_W      = 16;
  localparam int SZ_W       = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_FETCH_WAIT, ST_CHECK,
    ST_RD, ST_RD_WAIT, ST_WR, ST_WR_WAIT, ST_MINOR_END
  } seq_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [SZ_W-1:0]   ssize;
    logic [SZ_W-1:0]   dsize;
    logic [OFF_W-1:0]  soff;
    logic [WORD_W-1:0] nbytes;
    logic [WORD_W-1:0] dst;
    logic [CNT_W-1:0]  citer;
    logic [OFF_W-1:0]  doff;
    logic [WORD_W-1:0] next_ptr;
    logic [CNT_W-1:0]  biter;
    logic              sg_en;
    logic              half_ie;
    logic              major_ie;
    logic              go;
  } desc_t;
endpackage

// File: rtl/sgc_desc_capture.sv
module sgc_desc_capture
  import sgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_word,
  output desc_t             desc_q
);
  // Fields are picked straight out of each returned word; unused fields are never stored.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_q <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        IDX_W'(0): desc_q.src <= cap_word;
        IDX_W'(1): begin
          desc_q.ssize <= cap_word[26:24];
          desc_q.dsize <= cap_word[18:16];
          desc_q.soff  <= cap_word[15:0];
        end
        IDX_W'(2): desc_q.nbytes <= cap_word;
        IDX_W'(4): desc_q.dst <= cap_word;
        IDX_W'(5): begin
          desc_q.citer <= cap_word[24:16];
          desc_q.doff  <= cap_word[15:0];
        end
        IDX_W'(6): desc_q.next_ptr <= cap_word;
        IDX_W'(7): begin
          desc_q.biter    <= cap_word[24:16];
          desc_q.sg_en    <= cap_word[4];
          desc_q.half_ie  <= cap_word[2];
          desc_q.major_ie <= cap_word[1];
          desc_q.go       <= cap_word[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sgc_beat_path.sv
module sgc_beat_path
  import sgc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_init,
  input  logic [ADDR_W-1:0] dst_init,
  input  logic [WORD_W-1:0] nbytes,
  input  logic [OFF_W-1:0]  soff,
  input  logic [OFF_W-1:0]  doff,
  input  logic [1:0]        size_code,
  input  logic              rd_cap,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              step,
  input  logic              rearm,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [WORD_W-1:0] wr_word,
  output logic              last_beat
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [WORD_W-1:0] remain_q;
  logic [WORD_W-1:0] beat_bytes;
  logic [WORD_W-1:0] lane_mask;
  logic [ADDR_W-1:0] soff_ext, doff_ext;

  assign beat_bytes = WORD_W'(1) << size_code;
  assign last_beat  = (remain_q == beat_bytes);
  assign soff_ext   = {{EXT_W{soff[OFF_W-1]}}, soff};
  assign doff_ext   = {{EXT_W{doff[OFF_W-1]}}, doff};

  always_comb begin
    case (size_code)
      2'd0:    lane_mask = WORD_W'(8'hFF);
      2'd1:    lane_mask = WORD_W'(16'hFFFF);
      default: lane_mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      remain_q <= '0;
      wr_word  <= '0;
    end else begin
      if (load) begin
        src_addr <= src_init;
        dst_addr <= dst_init;
        remain_q <= nbytes;
      end else if (step) begin
        src_addr <= src_addr + soff_ext;
        dst_addr <= dst_addr + doff_ext;
        remain_q <= remain_q - beat_bytes;
      end else if (rearm) begin
        remain_q <= nbytes;
      end
      if (rd_cap) wr_word <= rd_word & lane_mask;
    end
  end

  AST_BEAT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> remain_q >= beat_bytes) else $error("beat past byte count"); // R3
endmodule

// File: rtl/sgc_major_cnt.sv
module sgc_major_cnt
  import sgc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] begin_val,
  input  logic             dec,
  input  logic             half_ie,
  input  logic             major_ie,
  output logic             last_iter,
  output logic             irq_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt   = cnt_q - CNT_W'(1);
  assign last_iter = (cnt_q == CNT_W'(1));
  assign irq_hit   = (half_ie && (cnt_nxt == (begin_val >> 1)) && (cnt_nxt != '0))
                   || (major_ie && last_iter);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= start_val;
    else if (dec && last_iter)  cnt_q <= begin_val;
    else if (dec)               cnt_q <= cnt_nxt;
  end

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0) else $error("major count underflow"); // R7
endmodule

// File: rtl/sgchain_seq.sv
module sgchain_seq
  import sgc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] chain_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata,
  input  logic              rsp_err,
  output logic              done,
  output logic              active,
  output logic              irq,
  output logic              err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              first_q, done_q, err_q, irq_q;
  desc_t             desc_q;
  logic              cfg_bad, run_ok, load, cap_en, rd_cap, step, rearm;
  logic              last_beat, last_iter, irq_hit;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [WORD_W-1:0] wr_word, beat_mask;

  assign beat_mask = (WORD_W'(1) << desc_q.ssize) - WORD_W'(1);
  assign cfg_bad = (desc_q.ssize > 3'd2) || (desc_q.ssize != desc_q.dsize) ||
                   (desc_q.nbytes == '0) || ((desc_q.nbytes & beat_mask) != '0) ||
                   (desc_q.citer == '0);
  assign run_ok = first_q || desc_q.go;
  assign load   = (state_q == ST_CHECK) && !cfg_bad && run_ok;
  assign cap_en = (state_q == ST_FETCH_WAIT) && rsp_valid && !rsp_err;
  assign rd_cap = (state_q == ST_RD_WAIT) && rsp_valid && !rsp_err;
  assign step   = (state_q == ST_WR_WAIT) && rsp_valid && !rsp_err;
  assign rearm  = (state_q == ST_MINOR_END) && !last_iter;

  sgc_desc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(idx_q),
    .cap_word(rsp_rdata), .desc_q(desc_q)
  );

  sgc_beat_path #(.ADDR_W(ADDR_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(load),
    .src_init(desc_q.src[ADDR_W-1:0]), .dst_init(desc_q.dst[ADDR_W-1:0]),
    .nbytes(desc_q.nbytes), .soff(desc_q.soff), .doff(desc_q.doff),
    .size_code(desc_q.ssize[1:0]), .rd_cap(rd_cap), .rd_word(rsp_rdata),
    .step(step), .rearm(rearm), .src_addr(src_addr), .dst_addr(dst_addr),
    .wr_word(wr_word), .last_beat(last_beat)
  );

  sgc_major_cnt u_major (
    .clk(clk), .rst_n(rst_n), .load(load), .start_val(desc_q.citer),
    .begin_val(desc_q.biter), .dec(state_q == ST_MINOR_END),
    .half_ie(desc_q.half_ie), .major_ie(desc_q.major_ie),
    .last_iter(last_iter), .irq_hit(irq_hit)
  );

  // Request channel is a pure function of registered state, so it holds under back-pressure.
  always_comb begin
    req_valid = (state_q == ST_FETCH) || (state_q == ST_RD) || (state_q == ST_WR);
    req_write = (state_q == ST_WR);
    req_wdata = (state_q == ST_WR) ? wr_word : '0;
    case (state_q)
      ST_RD:   begin req_addr = src_addr; req_size = desc_q.ssize[1:0]; end
      ST_WR:   begin req_addr = dst_addr; req_size = desc_q.dsize[1:0]; end
      default: begin req_addr = ptr_q + (ADDR_W'(idx_q) << 2); req_size = 2'd2; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          ptr_q   <= chain_base;
          idx_q   <= '0;
          first_q <= 1'b1;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (req_ready) state_q <= ST_FETCH_WAIT;
        ST_FETCH_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (idx_q == LAST_IDX) begin
            state_q <= ST_CHECK;
          end else begin
            idx_q <= idx_q + IDX_W'(1); state_q <= ST_FETCH;
          end
        end
        ST_CHECK: begin
          first_q <= 1'b0;
          if (cfg_bad) begin
            err_q <= 1'b1; state_q <= ST_IDLE;
          end else if (run_ok) begin
            state_q <= ST_RD;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_RD: if (req_ready) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          if (rsp_err) begin err_q <= 1'b1; state_q <= ST_IDLE; end
          else state_q <= ST_WR;
        end
        ST_WR: if (req_ready) state_q <= ST_WR_WAIT;
        ST_WR_WAIT: if (rsp_valid) begin
          if (rsp_err) begin err_q <= 1'b1; state_q <= ST_IDLE; end
          else state_q <= last_beat ? ST_MINOR_END : ST_RD;
        end
        ST_MINOR_END: begin
          irq_q <= irq_hit;
          if (!last_iter) begin
            state_q <= ST_RD;
          end else if (desc_q.sg_en) begin
            ptr_q   <= desc_q.next_ptr[ADDR_W-1:0];
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active = (state_q != ST_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign irq    = irq_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
      && $stable(req_size) && $stable(req_wdata)) else $error("request dropped"); // R4
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active && !err) else $error("done overlaps active/err"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !req_valid) else $error("request while inactive"); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("irq longer than a cycle"); // R7
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_size != 2'd3) else $error("illegal size code"); // R10
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (state_q == ST_FETCH_WAIT) || (state_q == ST_RD_WAIT)
      || (state_q == ST_WR_WAIT)) else $error("response without request"); // R4
endmodule

// File: tb/sgchain_seq_test.sv
module sgchain_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] chain_base = '0;
  logic        req_valid, req_write, req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        done, active, irq, err;

  always #10 clk = ~clk;

  sgchain_seq #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_base(chain_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .done(done), .active(active), .irq(irq), .err(err)
  );

  typedef struct { int kind; logic [31:0] addr; logic [31:0] data; int size; } ev_t;
  // kind: 0 descriptor fetch, 1 data read, 2 data write, 3 interrupt
  ev_t expq[$];
  byte unsigned mem [int unsigned];
  bit errset [int unsigned];
  int checks = 0, fails = 0;
  bit exp_done, exp_err, bp_on = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdn(input logic [31:0] a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++)
      v[8*i +: 8] = mem.exists(a + i) ? mem[a + i] : 8'h00;
    return v;
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endtask

  task automatic put_desc(input logic [31:0] at, src, dst, input logic [2:0] sz,
                          input logic [15:0] so, doff, input logic [31:0] nb,
                          input logic [8:0] cnt, input logic [31:0] nxt,
                          input bit sg, half, maj, go);
    wr32(at,      src);
    wr32(at + 4,  {5'h1F, sz, 5'h15, sz, so});        // modulo bits set: must be ignored (R2)
    wr32(at + 8,  nb);
    wr32(at + 12, 32'hDEAD_BEEF);                     // ignored word (R2)
    wr32(at + 16, dst);
    wr32(at + 20, {1'b1, 6'h2A, cnt, doff});
    wr32(at + 24, nxt);
    wr32(at + 28, {1'b1, 6'h15, cnt, 2'b11, 6'h3F, 1'b1, 1'b1, 1'b1, sg, 1'b1, half, maj, go});
  endtask

  task automatic push(input int k, input logic [31:0] a, input logic [31:0] d, input int s);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d; e.size = s;
    expq.push_back(e);
  endtask

  // Behavioural model: walks the chain from the requirements and lists expected events.
  task automatic build(input logic [31:0] first);
    logic [31:0] p, w1, w5, w7, s, d, nb, dat;
    int sz, cnt, bi;
    bit isfirst = 1'b1;
    p = first; exp_done = 1'b0; exp_err = 1'b0;
    forever begin
      for (int i = 0; i < 8; i++) begin
        push(0, p + 32'(4*i), 0, 2);
        if (errset.exists(p + 32'(4*i))) begin exp_err = 1'b1; return; end
      end
      s = rdn(p, 4); w1 = rdn(p + 4, 4); nb = rdn(p + 8, 4); d = rdn(p + 16, 4);
      w5 = rdn(p + 20, 4); w7 = rdn(p + 28, 4);
      sz = int'(w1[26:24]); cnt = int'(w5[24:16]); bi = int'(w7[24:16]);
      if (sz > 2 || w1[18:16] != w1[26:24] || nb == 0 || (nb % (1 << sz)) != 0 || cnt == 0) begin
        exp_err = 1'b1; return;
      end
      if (!isfirst && !w7[0]) return;
      while (cnt > 0) begin
        for (int b = 0; b < int'(nb) / (1 << sz); b++) begin
          push(1, s, 0, sz);
          if (errset.exists(s)) begin exp_err = 1'b1; return; end
          dat = rdn(s, 1 << sz);
          push(2, d, dat, sz);
          if (errset.exists(d)) begin exp_err = 1'b1; return; end
          s = s + {{16{w1[15]}}, w1[15:0]};
          d = d + {{16{w5[15]}}, w5[15:0]};
        end
        cnt--;
        if ((w7[2] && cnt == bi / 2 && cnt != 0) || (w7[1] && cnt == 0)) push(3, 0, 0, 0);
      end
      if (w7[4]) begin p = rdn(p + 24, 4); isfirst = 1'b0; end
      else begin exp_done = 1'b1; return; end
    end
  endtask

  // Memory slave, monitor and comparison, all at the falling edge.
  bit pend = 1'b0, perr = 1'b0, stall_seen = 1'b0;
  int pcnt = 0;
  logic [31:0] pdata, st_addr, st_wd;
  initial begin : slave
    ev_t e;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin rsp_valid = 1'b0; rsp_err = 1'b0; end
      if (pend) begin
        if (pcnt == 0) begin
          rsp_valid = 1'b1; rsp_rdata = pdata; rsp_err = perr; pend = 1'b0;
        end else pcnt--;
      end
      if (irq) begin
        if (expq.size() != 0 && expq[0].kind == 3) begin
          void'(expq.pop_front()); chk(1'b1, "R7/R8", "irq", 1, 1);
        end else chk(1'b0, "R7/R8", "unexpected irq", 1, 0);
      end
      if (stall_seen)
        chk(req_valid && req_addr == st_addr && req_wdata == st_wd, "R4",
            "request changed under back-pressure", req_addr, st_addr);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_ready = bp_on ? lfsr[0] : 1'b1;
      stall_seen = req_valid && !req_ready;
      st_addr = req_addr; st_wd = req_wdata;
      if (req_valid && req_ready) begin
        chk(active, "R1", "request without active", 0, 1);
        if (expq.size() == 0) chk(1'b0, "R3", "unexpected request", req_addr, 0);
        else begin
          e = expq.pop_front();
          case (e.kind)
            0: chk(!req_write && req_addr == e.addr && req_size == 2'd2, "R1/R5",
                   "descriptor fetch", req_addr, e.addr);
            1: chk(!req_write && req_addr == e.addr && req_size == 2'(e.size), "R3",
                   "data read", req_addr, e.addr);
            2: chk(req_write && req_addr == e.addr && req_size == 2'(e.size)
                   && req_wdata == e.data, "R3", "data write", req_wdata, e.data);
            default: chk(1'b0, "R7/R8", "request where irq due", req_addr, 0);
          endcase
        end
        perr = errset.exists(req_addr);
        pdata = (perr || req_write) ? 32'h0 : rdn(req_addr, 1 << req_size);
        if (req_write && !perr)
          for (int i = 0; i < (1 << req_size); i++) mem[req_addr + i] = req_wdata[8*i +: 8];
        pend = 1'b1;
        pcnt = bp_on ? int'(lfsr[2:1]) % 3 : 0;
      end
    end
  end

  task automatic run_chain(input logic [31:0] base, input string tag, input bit poke);
    build(base);
    @(negedge clk); start = 1'b1; chain_base = base;
    @(negedge clk); start = 1'b0;
    chk(active && !done && !err, "R1", "start clears status, raises active",
        {active, done, err}, 3'b100);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(active, "R11", "chain still running at second start", active, 1);
      start = 1'b1; chain_base = 32'h0000_0500;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 5000 && active; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, tag, "events left over", expq.size(), 0);
    chk(done == exp_done, "R6", "done at end", done, exp_done);
    chk(err == exp_err, "R9/R10", "err at end", err, exp_err);
    chk(!active, tag, "inactive at end", active, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    for (int a = 32'h1000; a < 32'h1100; a++) mem[a] = 8'(a * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!active && !done && !err && !irq && !req_valid, "R12", "reset state",
        {active, done, err, irq, req_valid}, 0);

    // R3 R6 R7: single descriptor, 4-byte beats, two iterations, end interrupt
    put_desc(32'h100, 32'h1000, 32'h2000, 3'd2, 16'd4, 16'd4, 32'd8, 9'd2, 32'h0, 0, 0, 1, 0);
    run_chain(32'h100, "R3", 1'b0);
    repeat (5) @(negedge clk);
    chk(done, "R6", "done held until next start", done, 1);

    // R5 R8 R11 R2: three-descriptor chain under back-pressure, negative offset, half interrupt
    bp_on = 1'b1;
    put_desc(32'h200, 32'h1010, 32'h3000, 3'd0, 16'd1, 16'd2, 32'd3, 9'd4, 32'h240, 1, 1, 0, 0);
    put_desc(32'h240, 32'h1020, 32'h3100, 3'd1, 16'd2, 16'hFFFE, 32'd4, 9'd2, 32'h280, 1, 0, 0, 1);
    put_desc(32'h280, 32'h1040, 32'h3200, 3'd2, 16'd4, 16'd4, 32'd8, 9'd3, 32'h0, 0, 1, 1, 1);
    run_chain(32'h200, "R5", 1'b1);

    // R5: second descriptor has start bit clear, channel parks
    put_desc(32'h300, 32'h1060, 32'h3300, 3'd1, 16'd2, 16'd2, 32'd2, 9'd1, 32'h340, 1, 0, 1, 0);
    put_desc(32'h340, 32'h1070, 32'h3400, 3'd2, 16'd4, 16'd4, 32'd4, 9'd1, 32'h0, 0, 0, 1, 0);
    run_chain(32'h300, "R5", 1'b0);

    // R9: write error on the second beat
    put_desc(32'h400, 32'h1080, 32'h4000, 3'd2, 16'd4, 16'd4, 32'd8, 9'd1, 32'h0, 0, 0, 1, 0);
    errset[32'h4004] = 1'b1;
    run_chain(32'h400, "R9", 1'b0);

    // R10: illegal size code and mismatched byte count
    put_desc(32'h500, 32'h1090, 32'h5000, 3'd3, 16'd8, 16'd8, 32'd8, 9'd1, 32'h0, 0, 0, 1, 0);
    run_chain(32'h500, "R10", 1'b0);
    put_desc(32'h540, 32'h1090, 32'h5000, 3'd2, 16'd4, 16'd4, 32'd6, 9'd1, 32'h0, 0, 0, 1, 0);
    run_chain(32'h540, "R10", 1'b0);

    // R9: error while fetching a descriptor
    bp_on = 1'b0;
    put_desc(32'h600, 32'h10A0, 32'h6000, 3'd0, 16'd1, 16'd1, 32'd1, 9'd1, 32'h0, 0, 0, 1, 0);
    errset[32'h608] = 1'b1;
    run_chain(32'h600, "R9", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule